// File: doc/BRIEF.md
# Recursive Sine Oscillator

This block produces a sinusoid without any sine table. It keeps the two most recent outputs in 16-bit signed state registers. On each sample strobe it forms the next value by multiplying the newest output by a frequency coefficient, rounding the product, and subtracting the older output. The coefficient alone sets the tone frequency relative to the strobe rate. A non-zero seed starts the oscillation. The size of the seed sets the peak amplitude, but the peak is not equal to the seed.

The coefficient is a signed fixed-point number with 14 fractional bits, equal to 2·cos(2π·fo/fs). For example, a 770 Hz tone at an 8 kHz strobe rate uses roughly 26955. Each new sample is also mapped to an unsigned 12-bit converter code centred on mid-scale.

The output side is a stream without back-pressure. A one-cycle valid pulse marks every new sample, and the consumer must take it in that cycle. A real-time tone cannot be stalled, so there is no ready input. The control pins (strobe and seed load) are plain level inputs that are sampled on each clock edge.

Top module: `recursive_sine_osc`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the newest state takes `seed_i` and the older state becomes 0. After reset, `sample_o` equals the seed and `sample_valid_o` is 0.
- R2: On an edge with `sample_stb_i`=1 and `seed_load_i`=0, the new sample is the saturated value of floor((k·y1 + 8192) / 16384) − y2. Here y1 is the newest state, y2 is the older state, and k is `coef_k_i` as a signed Q2.14 value. After the edge, y2 takes the old y1 and `sample_o` shows the new sample.
- R3: On an edge with neither strobe nor seed load, both states hold, and `sample_o` does not change.
- R4: `sample_valid_o` is 1 in the cycle after an edge that advanced the recurrence (R2), and 0 after every other edge.
- R5: A result above 32767 becomes 32767, and a result below −32768 becomes −32768.
- R6: `dac_code_o` equals `sample_o` arithmetically shifted right by 4, plus 2048, clamped to 0..4095.
- R7: On an edge with `seed_load_i`=1, the newest state takes `seed_i` and the older state becomes 0. This applies whatever the strobe does, and no valid pulse follows.
- R8: A zero seed keeps the output at 0 for any coefficient.
- R9: With k=0 and seed s, successive samples are 0, −s, 0, s, repeating with period 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| sample_stb_i | input | 1 | Advance the recurrence by one sample |
| seed_load_i | input | 1 | Restart from `seed_i` (has priority over the strobe) |
| coef_k_i | input | 16 | Frequency coefficient, signed Q2.14 |
| seed_i | input | 16 | Signed start value for the newest state |
| sample_o | output | 16 | Newest signed sample |
| dac_code_o | output | 12 | Offset-binary converter code for `sample_o` |
| sample_valid_o | output | 1 | One-cycle pulse after each new sample |

## Verification
The assertions assume that the strobe and seed load are ordinary synchronous levels. They also assume that the coefficient and seed are stable at the clock edge. They do not assume that the strobe is sparse: back-to-back strobes and a strobe together with a seed load are both legal. The stimulus drives every input half a cycle away from the sampling edge. It mixes dense and sparse strobes, and it sometimes asserts a seed load in the same cycle as a strobe. It changes the coefficient only at a seed load, so that saturation runs, the 770 Hz coefficient and k=0 each build up a clean history.

// File: rtl/sosc_pkg.sv
package sosc_pkg;
  localparam int unsigned SOSC_SAMPLE_W = 16;
  localparam int unsigned SOSC_COEF_W   = 16;
  localparam int unsigned SOSC_COEF_FRAC = 14;
  localparam int unsigned SOSC_DAC_W    = 12;

  typedef enum logic [1:0] {
    SOSC_OP_HOLD = 2'd0,
    SOSC_OP_STEP = 2'd1,
    SOSC_OP_SEED = 2'd2
  } sosc_op_e;
endpackage

// File: rtl/sosc_mac.sv
module sosc_mac #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned FRAC     = 14,
  localparam int unsigned PROD_W  = SAMPLE_W + COEF_W,
  localparam int unsigned RND_W   = PROD_W - FRAC
) (
  input  logic signed [COEF_W-1:0]   coef_i,
  input  logic signed [SAMPLE_W-1:0] y_i,
  output logic signed [RND_W-1:0]    rnd_o
);
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC - 1);

  logic signed [PROD_W-1:0] coef_ext;
  logic signed [PROD_W-1:0] y_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;

  always_comb begin
    coef_ext = {{SAMPLE_W{coef_i[COEF_W-1]}}, coef_i};
    y_ext    = {{COEF_W{y_i[SAMPLE_W-1]}}, y_i};
    prod     = coef_ext * y_ext;
    biased   = prod + HALF;
    rnd_o    = biased[PROD_W-1:FRAC];
  end
endmodule

// File: rtl/sosc_sat.sv
module sosc_sat #(
  parameter int unsigned IN_W  = 19,
  parameter int unsigned OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  in_i,
  output logic signed [OUT_W-1:0] out_o
);
  localparam int unsigned EXT = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] MAXV = {{EXT{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = {{EXT{1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (in_i > MAXV)      out_o = MAXV[OUT_W-1:0];
    else if (in_i < MINV) out_o = MINV[OUT_W-1:0];
    else                  out_o = in_i[OUT_W-1:0];
  end
endmodule

// File: rtl/sosc_dac_map.sv
module sosc_dac_map #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DAC_W    = 12,
  localparam int unsigned SHIFT   = SAMPLE_W - DAC_W,
  localparam int unsigned WIDE_W  = DAC_W + 2
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic [DAC_W-1:0]           code_o
);
  localparam logic signed [WIDE_W-1:0] OFFSET = WIDE_W'(1) << (DAC_W - 1);
  localparam logic signed [WIDE_W-1:0] TOP    = (WIDE_W'(1) << DAC_W) - WIDE_W'(1);

  logic signed [DAC_W-1:0]  shifted;
  logic signed [WIDE_W-1:0] wide;

  always_comb begin
    shifted = sample_i[SAMPLE_W-1:SHIFT];
    wide    = {{2{shifted[DAC_W-1]}}, shifted} + OFFSET;
    if (wide < 0)        code_o = '0;
    else if (wide > TOP) code_o = TOP[DAC_W-1:0];
    else                 code_o = wide[DAC_W-1:0];
  end
endmodule

// File: rtl/recursive_sine_osc.sv
module recursive_sine_osc
  import sosc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SOSC_SAMPLE_W,
  parameter int unsigned COEF_W   = SOSC_COEF_W,
  parameter int unsigned FRAC     = SOSC_COEF_FRAC,
  parameter int unsigned DAC_W    = SOSC_DAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_stb_i,
  input  logic                seed_load_i,
  input  logic [COEF_W-1:0]   coef_k_i,
  input  logic [SAMPLE_W-1:0] seed_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [DAC_W-1:0]    dac_code_o,
  output logic                sample_valid_o
);
  localparam int unsigned RND_W  = SAMPLE_W + COEF_W - FRAC;
  localparam int unsigned DIFF_W = RND_W + 1;

  logic signed [SAMPLE_W-1:0] y1_q, y2_q, y_next;
  logic signed [RND_W-1:0]    rnd;
  logic signed [DIFF_W-1:0]   diff;
  logic                       valid_q;
  sosc_op_e                   op;

  always_comb begin
    if (seed_load_i)       op = SOSC_OP_SEED;
    else if (sample_stb_i) op = SOSC_OP_STEP;
    else                   op = SOSC_OP_HOLD;
  end

  sosc_mac #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .FRAC(FRAC)) mac_i (
    .coef_i (coef_k_i),
    .y_i    (y1_q),
    .rnd_o  (rnd)
  );

  always_comb begin
    diff = {rnd[RND_W-1], rnd} - {{(DIFF_W-SAMPLE_W){y2_q[SAMPLE_W-1]}}, y2_q};
  end

  sosc_sat #(.IN_W(DIFF_W), .OUT_W(SAMPLE_W)) sat_i (
    .in_i  (diff),
    .out_o (y_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y1_q    <= seed_i;
      y2_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (op == SOSC_OP_STEP);
      case (op)
        SOSC_OP_SEED: begin
          y1_q <= seed_i;
          y2_q <= '0;
        end
        SOSC_OP_STEP: begin
          y1_q <= y_next;
          y2_q <= y1_q;
        end
        default: ;
      endcase
    end
  end

  sosc_dac_map #(.SAMPLE_W(SAMPLE_W), .DAC_W(DAC_W)) map_i (
    .sample_i (y1_q),
    .code_o   (dac_code_o)
  );

  assign sample_o       = y1_q;
  assign sample_valid_o = valid_q;

  // R3: idle edges leave both states untouched
  a_r3_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb_i && !seed_load_i) |=> ($stable(y1_q) && $stable(y2_q)));

  // R2: the older state takes the previous newest state on a step
  a_r2_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb_i && !seed_load_i) |=> (y2_q == $past(y1_q)));

  // R4: a step is followed by a valid pulse
  a_r4_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb_i && !seed_load_i) |=> sample_valid_o);

  // R4: no pulse without a step
  a_r4_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb_i && !seed_load_i) |=> !sample_valid_o);

  // R7: seed load restarts the recurrence
  a_r7_seed_restart: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_i |=> (y2_q == '0 && sample_o == $past(seed_i)));

  // R8: all-zero state stays at zero
  a_r8_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (y1_q == '0 && y2_q == '0 && !seed_load_i) |=> (sample_o == '0));
endmodule

// File: tb/recursive_sine_osc_tb_top.sv
module recursive_sine_osc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0;
  logic        load = 1'b0;
  logic [15:0] coef = '0;
  logic [15:0] seed = '0;
  logic [15:0] sample;
  logic [11:0] dac;
  logic        valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int  m_y1 = 0;
  int  m_y2 = 0;
  bit  m_valid = 1'b0;
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  recursive_sine_osc dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_stb_i   (stb),
    .seed_load_i    (load),
    .coef_k_i       (coef),
    .seed_i         (seed),
    .sample_o       (sample),
    .dac_code_o     (dac),
    .sample_valid_o (valid)
  );

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int next_sample(int k, int y1, int y2);
    longint p;
    longint r;
    p = longint'(k) * longint'(y1);
    r = (p + 8192) >>> 14;
    return sat16(r - longint'(y2));
  endfunction

  function automatic int dac_of(int y);
    int c;
    c = (y >>> 4) + 2048;
    if (c < 0) c = 0;
    if (c > 4095) c = 4095;
    return c;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, advance the model, then compare at the falling edge
  task automatic cycle(bit r, bit ld, bit st, int k, int s);
    rst_n = r; load = ld; stb = st;
    coef = 16'(k); seed = 16'(s);
    if (!r) begin
      m_y1 = s; m_y2 = 0; m_valid = 0; m_tag = "R1";
    end else if (ld) begin
      m_y1 = s; m_y2 = 0; m_valid = 0; m_tag = "R7";
    end else if (st) begin
      int n;
      n = next_sample(k, m_y1, m_y2);
      m_y2 = m_y1; m_y1 = n; m_valid = 1; m_tag = "R2";
    end else begin
      m_valid = 0; m_tag = "R3";
    end
    @(posedge clk);
    @(negedge clk);
    check(m_tag, int'($signed(sample)), m_y1);
    check("R4", int'(valid), int'(m_valid));
    check("R6", int'(dac), dac_of(m_y1));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k;
    int s;
    void'($urandom(32'h5eed_0770));
    @(negedge clk);
    // R1: reset loads the seed
    cycle(0, 0, 0, 0, 1234);
    cycle(0, 1, 1, 0, 1234);
    check("R1", int'($signed(sample)), 1234);
    check("R1", int'(valid), 0);

    // R9: k = 0 gives 0, -s, 0, s
    cycle(1, 1, 0, 0, 1000);
    for (int i = 0; i < 8; i++) begin
      int exp9;
      cycle(1, 0, 1, 0, 1000);
      case (i % 4)
        0: exp9 = 0;
        1: exp9 = -1000;
        2: exp9 = 0;
        default: exp9 = 1000;
      endcase
      check("R9", int'($signed(sample)), exp9);
    end

    // R5: positive and negative saturation
    cycle(1, 1, 0, 32767, 32767);
    cycle(1, 0, 1, 32767, 32767);
    check("R5", int'($signed(sample)), 32767);
    check("R6", int'(dac), 4095);
    cycle(1, 1, 0, 32767, -32768);
    cycle(1, 0, 1, 32767, -32768);
    check("R5", int'($signed(sample)), -32768);
    check("R6", int'(dac), 0);

    // R8: zero seed stays at zero
    cycle(1, 1, 0, 26955, 0);
    for (int i = 0; i < 6; i++) begin
      cycle(1, 0, 1, 26955, 0);
      check("R8", int'($signed(sample)), 0);
    end

    // R7: load together with strobe wins, no valid pulse
    cycle(1, 1, 0, 26955, 3000);
    cycle(1, 0, 1, 26955, 3000);
    cycle(1, 1, 1, 26955, -77);
    check("R7", int'($signed(sample)), -77);
    check("R7", int'(valid), 0);

    // R3: idle cycles with changing seed/coef have no effect
    cycle(1, 0, 1, 26955, 0);
    for (int i = 0; i < 4; i++) cycle(1, 0, 0, int'($urandom) & 16'hffff, int'($urandom) & 16'hffff);

    // R2: 770 Hz tone at 8 kHz, dense strobes
    cycle(1, 1, 0, 26955, 12000);
    for (int i = 0; i < 200; i++) cycle(1, 0, 1, 26955, 12000);

    // constrained random mix
    k = 26955; s = 8000;
    for (int i = 0; i < 4000; i++) begin
      bit ld;
      bit st;
      ld = (($urandom % 64) == 0);
      st = (($urandom % 3) != 0);
      if (ld) begin
        k = int'($signed(16'($urandom)));
        s = int'($signed(16'($urandom)));
      end
      if (($urandom % 500) == 0) cycle(0, 0, 0, k, s);
      else cycle(1, ld, st, k, s);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule